// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Register

This block keeps the interrupt event flags of a USB device controller and turns them into two interrupt request lines for the processor. The USB core sends single-cycle event pulses for bus reset, setup reception and the endpoint-0 and endpoint-2 transfer events. Each pulse latches a sticky flag. The endpoint FIFOs supply two level signals, endpoint-1 full and endpoint-2 empty. These appear in the flag word as live status that software cannot clear.

Software clears a sticky flag by writing 0 to its bit, and writes 1 to every bit it wants to keep. Each flag is gated by a bit in an enable register. A bit in a select register then steers it to one of two request lines. Each line is the OR of all sources routed to it, so it stays high until every contributing flag is cleared or disabled.

Top module: `usb_ep_irq_flags`

## Requirements
- R1: While reset is asserted, the flag word reads 0x0000_0010, so only bit 4 (endpoint-2 empty) is 1. The enable and select registers read 0, and both request lines are low.
- R2: The flag bits are, from bit 7 down to bit 0: bus reset, endpoint-1 full, endpoint-2 transfer request, endpoint-2 empty, setup received, endpoint-0 out complete, endpoint-0 in request, endpoint-0 in complete. A pulse on `evt_pulse[i]` for a sticky bit i (7, 5, 3, 2, 1 or 0) sets that flag at the next clock edge. The flag then stays set until software clears it.
- R3: A write to address 0 clears each sticky flag whose write-data bit is 0. A sticky flag whose write-data bit is 1 is left unchanged.
- R4: If an event pulse and a clearing write reach the same sticky bit in the same cycle, the flag ends up set.
- R5: Bit 6 shows `ep1_fifo_full` and bit 4 shows `ep2_fifo_empty`, each one clock after it is sampled. No write changes these two bits, and event pulses on bits 6 and 4 are ignored.
- R6: Bits 31 to 8 read 0 at every address. Address 3 reads 0 as a whole.
- R7: The enable register is at address 1 and the select register at address 2. Each is an 8-bit read/write register, and write-data bits 31 to 8 are discarded.
- R8: `irq_line0` is high when some flag has both its flag and enable bits at 1 and its select bit at 0. `irq_line1` is high under the same conditions but with the select bit at 1. Both lines are level outputs driven from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 2 | Register select: 0 flags, 1 enable, 2 select, 3 unused |
| cpu_wr | input | 1 | Write strobe for the addressed register |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Combinational read data of the addressed register |
| evt_pulse | input | 8 | Single-cycle event pulses, one per flag position |
| ep1_fifo_full | input | 1 | Endpoint-1 FIFO full level |
| ep2_fifo_empty | input | 1 | Endpoint-2 FIFO empty level |
| irq_line0 | output | 1 | Request line for sources with select bit 0 |
| irq_line1 | output | 1 | Request line for sources with select bit 1 |

## Verification
The properties assume that `evt_pulse` and the write strobe are sampled only at clock edges. They also assume that a write always addresses one of the four register slots, so any 2-bit value of `cpu_addr` is legal. The FIFO levels may change on any cycle, and the checks compare them against the previous cycle rather than assuming they hold steady. The stimulus changes every input only at the falling edge. Its random phase mixes pulses on all eight event bits, including the two live positions, with writes to all four addresses, so the ignored-pulse and set-versus-clear cases also occur outside the directed tests.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int SRC_COUNT     = 8;
    localparam int BUS_WIDTH     = 32;
    localparam int SEL_WIDTH     = 2;
    localparam int FULL_POS      = 6;
    localparam int EMPTY_POS     = 4;

    typedef enum logic [1:0] {
        SLOT_FLAGS  = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_ROUTE  = 2'd2,
        SLOT_SPARE  = 2'd3
    } reg_slot_e;

endpackage

// File: rtl/usb_irq_flag_bank.sv
module usb_irq_flag_bank #(
    parameter int                   NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0]   LIVE_MASK = 8'h50,
    parameter logic [NUM_SRC-1:0]   LIVE_RST  = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] live_in,
    input  logic               clr_req,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] flags
);
    localparam logic [NUM_SRC-1:0] STICKY_MASK = ~LIVE_MASK;

    typedef struct packed {
        logic [NUM_SRC-1:0] sticky;
        logic [NUM_SRC-1:0] live;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_SRC-1:0] wipe;

    always_comb begin
        st_d = st_q;
        wipe = clr_req ? ~clr_data : '0;
        // set has priority over a simultaneous clear
        st_d.sticky = ((st_q.sticky & ~wipe) | evt) & STICKY_MASK;
        st_d.live   = live_in & LIVE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sticky <= '0;
            st_q.live   <= LIVE_RST & LIVE_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.sticky | st_q.live;

endmodule

// File: rtl/usb_irq_cfg_regs.sv
module usb_irq_cfg_regs #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_enable,
    input  logic               wr_route,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] enable_vec,
    output logic [NUM_SRC-1:0] route_vec
);
    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_enable) cfg_d.enable = wr_data;
        if (wr_route)  cfg_d.route  = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_vec = cfg_q.enable;
    assign route_vec  = cfg_q.route;

endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] enable_vec,
    input  logic [NUM_SRC-1:0] route_vec,
    output logic               line0,
    output logic               line1
);
    logic [NUM_SRC-1:0] hit0;
    logic [NUM_SRC-1:0] hit1;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic armed;
        assign armed   = flags[i] & enable_vec[i];
        assign hit0[i] = armed & ~route_vec[i];
        assign hit1[i] = armed &  route_vec[i];
    end

    assign line0 = |hit0;
    assign line1 = |hit1;

endmodule

// File: rtl/usb_ep_irq_flags.sv
module usb_ep_irq_flags
    import usb_irq_pkg::*;
#(
    parameter int NUM_SRC   = SRC_COUNT,
    parameter int DATA_W    = BUS_WIDTH,
    parameter int ADDR_W    = SEL_WIDTH,
    parameter int FULL_BIT  = FULL_POS,
    parameter int EMPTY_BIT = EMPTY_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic              ep1_fifo_full,
    input  logic              ep2_fifo_empty,
    output logic              irq_line0,
    output logic              irq_line1
);
    localparam logic [NUM_SRC-1:0] LIVE_MASK =
        (NUM_SRC'(1) << FULL_BIT) | (NUM_SRC'(1) << EMPTY_BIT);
    localparam logic [NUM_SRC-1:0] LIVE_RST = NUM_SRC'(1) << EMPTY_BIT;
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] live_vec;
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] sel_vec;
    logic [NUM_SRC-1:0] wr_bits;
    logic               wr_flags, wr_en, wr_sel;
    reg_slot_e          slot;

    assign slot     = reg_slot_e'(cpu_addr[1:0]);
    assign wr_bits  = cpu_wdata[NUM_SRC-1:0];
    assign wr_flags = cpu_wr && (slot == SLOT_FLAGS);
    assign wr_en    = cpu_wr && (slot == SLOT_ENABLE);
    assign wr_sel   = cpu_wr && (slot == SLOT_ROUTE);

    always_comb begin
        live_vec            = '0;
        live_vec[FULL_BIT]  = ep1_fifo_full;
        live_vec[EMPTY_BIT] = ep2_fifo_empty;
    end

    usb_irq_flag_bank #(
        .NUM_SRC   (NUM_SRC),
        .LIVE_MASK (LIVE_MASK),
        .LIVE_RST  (LIVE_RST)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse & ~LIVE_MASK),
        .live_in  (live_vec),
        .clr_req  (wr_flags),
        .clr_data (wr_bits),
        .flags    (flag_vec)
    );

    usb_irq_cfg_regs #(
        .NUM_SRC (NUM_SRC)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (wr_en),
        .wr_route   (wr_sel),
        .wr_data    (wr_bits),
        .enable_vec (en_vec),
        .route_vec  (sel_vec)
    );

    usb_irq_router #(
        .NUM_SRC (NUM_SRC)
    ) u_route (
        .flags      (flag_vec),
        .enable_vec (en_vec),
        .route_vec  (sel_vec),
        .line0      (irq_line0),
        .line1      (irq_line1)
    );

    always_comb begin
        unique case (slot)
            SLOT_FLAGS:  cpu_rdata = {{PAD_W{1'b0}}, flag_vec};
            SLOT_ENABLE: cpu_rdata = {{PAD_W{1'b0}}, en_vec};
            SLOT_ROUTE:  cpu_rdata = {{PAD_W{1'b0}}, sel_vec};
            default:     cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/usb_ep_irq_flags_chk.sv
module usb_ep_irq_flags_chk #(
    parameter int                 NUM_SRC   = 8,
    parameter int                 DATA_W    = 32,
    parameter int                 FULL_BIT  = 6,
    parameter int                 EMPTY_BIT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cpu_addr,
    input logic               cpu_wr,
    input logic [DATA_W-1:0]  cpu_wdata,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               ep1_fifo_full,
    input logic               ep2_fifo_empty,
    input logic [NUM_SRC-1:0] flag_vec,
    input logic [NUM_SRC-1:0] en_vec,
    input logic               irq_line0,
    input logic               irq_line1
);
    localparam logic [NUM_SRC-1:0] LIVE =
        (NUM_SRC'(1) << FULL_BIT) | (NUM_SRC'(1) << EMPTY_BIT);
    localparam logic [NUM_SRC-1:0] STICKY = ~LIVE;

    logic clr_w;
    assign clr_w = cpu_wr && (cpu_addr == 2'd0);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & STICKY) != '0) |=>
        ((flag_vec & $past(evt_pulse & STICKY)) == $past(evt_pulse & STICKY)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=>
        ((flag_vec & $past(~cpu_wdata[NUM_SRC-1:0] & ~evt_pulse & STICKY)) == '0));

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_w && ((evt_pulse & STICKY) == '0)) |=>
        ((flag_vec & STICKY) == $past(flag_vec & STICKY)));

    p_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_vec[FULL_BIT] == $past(ep1_fifo_full) &&
                  flag_vec[EMPTY_BIT] == $past(ep2_fifo_empty)));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1:NUM_SRC] == '0);

    p_line_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line0 || irq_line1) |-> ((flag_vec & en_vec) != '0));

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> (!irq_line0 && !irq_line1));

endmodule

bind usb_ep_irq_flags usb_ep_irq_flags_chk #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .FULL_BIT  (FULL_BIT),
    .EMPTY_BIT (EMPTY_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rdata      (cpu_rdata),
    .evt_pulse      (evt_pulse),
    .ep1_fifo_full  (ep1_fifo_full),
    .ep2_fifo_empty (ep2_fifo_empty),
    .flag_vec       (flag_vec),
    .en_vec         (en_vec),
    .irq_line0      (irq_line0),
    .irq_line1      (irq_line1)
);

// File: tb/usb_ep_irq_flags_test.sv
`timescale 1ns/1ps
module usb_ep_irq_flags_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cpu_addr;
    logic        cpu_wr;
    logic [31:0] cpu_wdata;
    logic [31:0] cpu_rdata;
    logic [7:0]  evt_pulse;
    logic        ep1_fifo_full;
    logic        ep2_fifo_empty;
    logic        irq_line0;
    logic        irq_line1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    int m_sticky, m_full, m_empty, m_en, m_sel;

    always #10 clk = ~clk;

    usb_ep_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .evt_pulse(evt_pulse),
        .ep1_fifo_full(ep1_fifo_full), .ep2_fifo_empty(ep2_fifo_empty),
        .irq_line0(irq_line0), .irq_line1(irq_line1)
    );

    function automatic int flag_word();
        return m_sticky | (m_full << 6) | (m_empty << 4);
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            0: return flag_word();
            1: return m_en;
            2: return m_sel;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_line(input int which);
        int f = flag_word();
        for (int i = 0; i < 8; i++) begin
            if (((f >> i) & 1) && ((m_en >> i) & 1) && (((m_sel >> i) & 1) == which))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rdata", cpu_rdata, exp_read(cpu_addr));
        check(tag, "irq_line0", irq_line0, exp_line(0));
        check(tag, "irq_line1", irq_line1, exp_line(1));
    endtask

    // one clock: drive at falling edge, update model at rising edge, compare at next falling edge
    task automatic cyc(input int a, input bit w, input logic [31:0] d, input logic [7:0] e,
                       input bit ff, input bit fe, input string tag);
        int wipe;
        cpu_addr = 2'(a); cpu_wr = w; cpu_wdata = d; evt_pulse = e;
        ep1_fifo_full = ff; ep2_fifo_empty = fe;
        @(posedge clk);
        wipe = (w && a == 0) ? (~d & 32'hFF) : 0;
        m_sticky = ((m_sticky & ~wipe) | e) & 8'hAF;
        m_full  = ff; m_empty = fe;
        if (w && a == 1) m_en  = d & 32'hFF;
        if (w && a == 2) m_sel = d & 32'hFF;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic rd(input int a, input string tag);
        cyc(a, 0, 32'h0, 8'h0, ep1_fifo_full, ep2_fifo_empty, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cpu_addr = 0; cpu_wr = 0; cpu_wdata = 0; evt_pulse = 0;
        ep1_fifo_full = 0; ep2_fifo_empty = 0;
        m_sticky = 0; m_full = 0; m_empty = 1; m_en = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        // R1: reset contents and quiet request lines
        for (int a = 0; a < 4; a++) begin
            cpu_addr = 2'(a); #1;
            check("R1", "reset read", cpu_rdata, (a == 0) ? 32'h10 : 32'h0);
        end
        check("R1", "reset irq_line0", irq_line0, 0);
        check("R1", "reset irq_line1", irq_line1, 0);
        rst_n = 1;

        // R7: enable and select are plain 8-bit registers, upper data dropped
        cyc(1, 1, 32'hFFFF_FF00, 8'h0, 0, 0, "R7");
        rd(1, "R7");
        cyc(1, 1, 32'h1234_56FF, 8'h0, 0, 0, "R7");
        cyc(2, 1, 32'hABCD_EF0F, 8'h0, 0, 0, "R7");
        rd(2, "R7");

        // R2: each sticky position latches and holds
        cyc(0, 0, 0, 8'h80, 0, 0, "R2");
        rd(0, "R2");
        cyc(0, 0, 0, 8'h2F, 0, 0, "R2");
        repeat (3) rd(0, "R2");

        // R5: pulses on live positions ignored, levels follow inputs
        cyc(0, 1, 32'h0, 8'h0, 0, 0, "R3");
        cyc(0, 0, 0, 8'h50, 0, 0, "R5");
        cyc(0, 0, 0, 8'h00, 1, 0, "R5");
        cyc(0, 0, 0, 8'h00, 1, 1, "R5");
        cyc(0, 1, 32'h0, 8'h0, 1, 1, "R5");
        rd(0, "R5");
        cyc(0, 0, 0, 8'h00, 0, 1, "R5");

        // R3: write-0 clears, write-1 keeps
        cyc(0, 0, 0, 8'hAF, 0, 0, "R3");
        cyc(0, 1, 32'hFFFF_FFFF, 8'h0, 0, 0, "R3");
        cyc(0, 1, 32'hFFFF_FFDE, 8'h0, 0, 0, "R3");
        cyc(0, 1, 32'h0000_00FF, 8'h0, 0, 0, "R3");
        cyc(0, 1, 32'h0000_0000, 8'h0, 0, 0, "R3");

        // R4: set wins over a same-cycle clear
        cyc(0, 1, 32'h0, 8'h81, 0, 0, "R4");
        rd(0, "R4");

        // R6: upper bits and spare address read zero
        cyc(3, 1, 32'hFFFF_FFFF, 8'h0, 1, 1, "R6");
        rd(3, "R6");

        // R8: routing with mixed enables and selects
        cyc(1, 1, 32'h05, 8'h0, 0, 0, "R8");
        cyc(2, 1, 32'h04, 8'h0, 0, 0, "R8");
        cyc(0, 0, 0, 8'h04, 0, 0, "R8");
        cyc(0, 1, 32'hFB, 8'h0, 0, 0, "R8");
        cyc(1, 1, 32'h10, 8'h0, 0, 1, "R8");
        rd(0, "R8");

        // mixed random traffic, all requirements against the model
        for (int n = 0; n < 600; n++) begin
            int a = $urandom_range(0, 3);
            bit w = ($urandom_range(0, 3) == 0);
            logic [7:0] e = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h0;
            cyc(a, w, $urandom, e, 1'($urandom), 1'($urandom), "R8");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule